// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the master-side sequencer for a processor with an 8-bit data path that shares its low address byte with the data lines. Internal logic hands it one transfer at a time: code fetch, memory read, memory write, I/O read, I/O write or interrupt acknowledge. The block runs that transfer as a bus cycle of four clock states, T1 to T4. Wait states go between T3 and T4 for as long as the target holds READY low.

The block drives the shared address/data lines, the middle and top address lines, an address latch strobe, the read, write and acknowledge strobes, the memory/I/O select, the buffer direction and the buffer enable. The top address nibble carries the address in T1 and a small status code after T1. Electrical tri-state is modelled by output-enable flags. In single-acknowledge mode an interrupt acknowledge is one cycle. In paired mode it is two cycles back to back, with a lock output held low across both, and the vector is taken from the second cycle. Between cycles the block grants external bus-hold requests and releases every pin group while the hold lasts.

Top module: `bus_cycle_seq`

## Requirements
- R1: `req_ready` is high exactly when the sequencer is idle and `hold` is low. A request accepted at a clock edge (`req_valid` and `req_ready`) has its T1 state in the following clock.
- R2: `req_kind` encodes the cycle type: 0 acknowledge, 1 I/O read, 2 I/O write, 4 code fetch, 5 memory read, 6 memory write. Codes 3 and 7 run as reads. `iom` equals the inverse of kind bit 2, from T1 through T4.
- R3: `ale` is high for exactly the one clock of T1. In T1, `ad_out` carries address bits 7:0 with `ad_oe` high, except in acknowledge cycles. `a_mid` carries address bits 15:8 throughout the cycle.
- R4: `a_top` carries address bits 19:16 in T1. From T2 to T4 it carries the status code {0, 0, write, iom}, with write in bit 1 and iom in bit 0.
- R5: Only one of `rd_n`, `wr_n` and `inta_n` is ever low. The strobe that matches the cycle type is low in T2, T3 and every TW, and high otherwise. `den_n` is low in those same states.
- R6: In read and acknowledge cycles, `ad_oe` is low after T1 and `dtr` is 0 (receive). In write cycles, `ad_oe` stays high from T1 to T4, `ad_out` carries the write data after T1, and `dtr` is 1 (transmit).
- R7: READY is sampled at the clock edge that ends T3 or a TW. A low sample adds one TW, and all outputs hold their values through it. The active strobe is therefore low for 2 + (number of wait states) clocks.
- R8: `done` is high for one clock, in T4 of the last cycle of a transfer. In read and acknowledge transfers, `rdata` then holds `ad_in` as sampled at the edge that left T3 or TW with READY high.
- R9: When `mode_min` is 1 at acceptance, an acknowledge is a single cycle. When it is 0, the acknowledge is two cycles, the second T1 directly after the first T4. `lock_n` is low in every state of both cycles, `done` is issued only after the second cycle, and the vector comes from the second cycle.
- R10: In the idle state, `hold` takes priority over a pending request. `hlda` rises one clock after `hold` is seen there. A hold raised during a cycle, or between paired acknowledge cycles, is granted only one clock after the final T4. While `hlda` is high, `ad_oe`, `addr_oe` and `ctl_oe` are low.
- R11: `hlda` drops one clock after `hold` is seen low. A pending request is accepted in that clock, and its T1 follows on the next clock.
- R12: While `rst_n` is low, `ale`, `done`, `hlda` and `ad_oe` are low, and `rd_n`, `wr_n`, `inta_n` and `lock_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_min | input | 1 | 1 = single acknowledge cycle, 0 = paired acknowledge cycles |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_kind | input | 3 | Cycle type code |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | Transfer complete pulse |
| rdata | output | DATA_W | Read data or interrupt vector |
| ready | input | 1 | Target ready; low inserts a wait state |
| hold | input | 1 | External bus-hold request |
| hlda | output | 1 | Bus-hold grant |
| ad_in | input | DATA_W | Shared lines, incoming value |
| ad_out | output | DATA_W | Shared lines, driven value |
| ad_oe | output | 1 | Shared lines driven |
| a_mid | output | ADDR_W-DATA_W-TOP_W | Middle address lines |
| a_top | output | TOP_W | Top address or status lines |
| addr_oe | output | 1 | Address and status lines driven |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| iom | output | 1 | 1 = I/O space, 0 = memory space |
| dtr | output | 1 | Buffer direction, 1 = transmit |
| den_n | output | 1 | Buffer enable, active low |
| lock_n | output | 1 | Bus lock across paired acknowledge, active low |
| ctl_oe | output | 1 | Control lines driven |

## Verification
A wrong state register shows up at the pins within one clock. An early or late T1 moves the `ale` pulse and the address on the shared lines. A lost or extra wait state changes how many clocks the strobe stays low, and that count is checked against READY on every transfer. A wrong kind or pair latch appears as a wrong strobe, status nibble, `iom` or `lock_n` level in T2, or as a missing second acknowledge T1. A fault in the hold path shows as `hlda` rising one clock early or late, or as output enables left high during the grant.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_T3,
    ST_TW,
    ST_T4,
    ST_HOLD
  } bus_st_e;

  localparam int KIND_W = 3;

  function automatic logic kind_is_ack(input logic [KIND_W-1:0] k);
    return (k == '0);
  endfunction

  function automatic logic kind_is_write(input logic [KIND_W-1:0] k);
    return k[1] & ~k[0];
  endfunction

  function automatic logic kind_is_io(input logic [KIND_W-1:0] k);
    return ~k[2];
  endfunction

endpackage

// File: rtl/bcs_ctl.sv
module bcs_ctl
  import bcs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    hold,
  input  logic    ready,
  input  logic    pair,
  output bus_st_e state,
  output logic    second,
  output logic    req_ready,
  output logic    load,
  output logic    cap_en
);

  bus_st_e st_q, st_d;
  logic    sec_q, sec_d;

  always_comb begin
    st_d  = st_q;
    sec_d = sec_q;
    unique case (st_q)
      ST_IDLE: begin
        if (hold)           st_d = ST_HOLD;
        else if (req_valid) st_d = ST_T1;
      end
      ST_T1:   st_d = ST_T2;
      ST_T2:   st_d = ST_T3;
      ST_T3,
      ST_TW:   st_d = ready ? ST_T4 : ST_TW;
      ST_T4: begin
        if (pair && !sec_q) begin
          st_d  = ST_T1;
          sec_d = 1'b1;
        end else begin
          st_d  = ST_IDLE;
          sec_d = 1'b0;
        end
      end
      ST_HOLD: st_d = hold ? ST_HOLD : ST_IDLE;
      default: begin
        st_d  = ST_IDLE;
        sec_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      sec_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      sec_q <= sec_d;
    end
  end

  assign state     = st_q;
  assign second    = sec_q;
  assign req_ready = (st_q == ST_IDLE) && !hold;
  assign load      = req_ready && req_valid;
  assign cap_en    = ((st_q == ST_T3) || (st_q == ST_TW)) && ready;

endmodule

// File: rtl/bcs_req_reg.sv
module bcs_req_reg
  import bcs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              cap_en,
  input  logic              mode_min,
  input  logic [KIND_W-1:0] req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] ad_in,
  output logic [KIND_W-1:0] kind_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              pair_q,
  output logic [DATA_W-1:0] rdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      pair_q  <= 1'b0;
    end else if (load) begin
      kind_q  <= req_kind;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      pair_q  <= kind_is_ack(req_kind) && !mode_min;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= ad_in;
  end

endmodule

// File: rtl/bcs_drive.sv
module bcs_drive
  import bcs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 20,
  parameter int TOP_W  = 4
) (
  input  bus_st_e                          state,
  input  logic                             second,
  input  logic [KIND_W-1:0]                kind,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [DATA_W-1:0]                wdata,
  input  logic                             pair,
  output logic [DATA_W-1:0]                ad_out,
  output logic                             ad_oe,
  output logic [ADDR_W-DATA_W-TOP_W-1:0]   a_mid,
  output logic [TOP_W-1:0]                 a_top,
  output logic                             addr_oe,
  output logic                             ctl_oe,
  output logic                             ale,
  output logic                             rd_n,
  output logic                             wr_n,
  output logic                             inta_n,
  output logic                             iom,
  output logic                             dtr,
  output logic                             den_n,
  output logic                             lock_n,
  output logic                             done,
  output logic                             hlda
);

  localparam int MID_W = ADDR_W - DATA_W - TOP_W;
  localparam int PAD_W = TOP_W - 2;

  logic is_ack, is_wr, is_rd, is_io;
  logic in_t1, in_strobe, in_cycle, in_data;
  logic [TOP_W-1:0] status;

  always_comb begin
    is_ack    = kind_is_ack(kind);
    is_wr     = kind_is_write(kind);
    is_io     = kind_is_io(kind);
    is_rd     = !is_ack && !is_wr;
    in_t1     = (state == ST_T1);
    in_strobe = (state == ST_T2) || (state == ST_T3) || (state == ST_TW);
    in_data   = in_strobe || (state == ST_T4);
    in_cycle  = in_t1 || in_data;
    status    = {{PAD_W{1'b0}}, is_wr, is_io};
  end

  always_comb begin
    ale     = in_t1;
    ad_oe   = (in_t1 && !is_ack) || (is_wr && in_data);
    ad_out  = in_t1 ? addr[DATA_W-1:0] : wdata;
    a_mid   = addr[DATA_W +: MID_W];
    a_top   = in_t1 ? addr[ADDR_W-1 -: TOP_W] : status;
    hlda    = (state == ST_HOLD);
    addr_oe = !hlda;
    ctl_oe  = !hlda;
    rd_n    = !(in_strobe && is_rd);
    wr_n    = !(in_strobe && is_wr);
    inta_n  = !(in_strobe && is_ack);
    den_n   = !in_strobe;
    dtr     = is_wr;
    iom     = is_io;
    lock_n  = !(pair && in_cycle);
    done    = (state == ST_T4) && (!pair || second);
  end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 20,
  parameter int TOP_W  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           mode_min,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [2:0]                     req_kind,
  input  logic [ADDR_W-1:0]              req_addr,
  input  logic [DATA_W-1:0]              req_wdata,
  output logic                           done,
  output logic [DATA_W-1:0]              rdata,
  input  logic                           ready,
  input  logic                           hold,
  output logic                           hlda,
  input  logic [DATA_W-1:0]              ad_in,
  output logic [DATA_W-1:0]              ad_out,
  output logic                           ad_oe,
  output logic [ADDR_W-DATA_W-TOP_W-1:0] a_mid,
  output logic [TOP_W-1:0]               a_top,
  output logic                           addr_oe,
  output logic                           ale,
  output logic                           rd_n,
  output logic                           wr_n,
  output logic                           inta_n,
  output logic                           iom,
  output logic                           dtr,
  output logic                           den_n,
  output logic                           lock_n,
  output logic                           ctl_oe
);

  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  bus_st_e           state;
  logic              second, load, cap_en, pair_q;
  logic [KIND_W-1:0] kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  bcs_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .req_valid (req_valid),
    .hold      (hold),
    .ready     (ready),
    .pair      (pair_q),
    .state     (state),
    .second    (second),
    .req_ready (req_ready),
    .load      (load),
    .cap_en    (cap_en)
  );

  bcs_req_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_req (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .load      (load),
    .cap_en    (cap_en),
    .mode_min  (mode_min),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ad_in     (ad_in),
    .kind_q    (kind_q),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .pair_q    (pair_q),
    .rdata_q   (rdata)
  );

  bcs_drive #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TOP_W(TOP_W)) u_drv (
    .state   (state),
    .second  (second),
    .kind    (kind_q),
    .addr    (addr_q),
    .wdata   (wdata_q),
    .pair    (pair_q),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe),
    .a_mid   (a_mid),
    .a_top   (a_top),
    .addr_oe (addr_oe),
    .ctl_oe  (ctl_oe),
    .ale     (ale),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .inta_n  (inta_n),
    .iom     (iom),
    .dtr     (dtr),
    .den_n   (den_n),
    .lock_n  (lock_n),
    .done    (done),
    .hlda    (hlda)
  );

endmodule

// File: rtl/bcs_chk.sv
module bcs_chk (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic inta_n,
  input logic ready,
  input logic hold,
  input logic hlda,
  input logic ad_oe,
  input logic addr_oe,
  input logic ctl_oe,
  input logic done
);

  // R3
  ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!rd_n, !wr_n, !inta_n}) <= 1);

  // R7
  wait_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && $past(!rd_n) && !ready) |=> !rd_n);

  // R10
  grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!ad_oe && !addr_oe && !ctl_oe));

  // R10
  grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> $past(hold && rd_n && wr_n && inta_n && !done));

  // R11
  grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hlda) |-> $past(!hold));

endmodule

bind bus_cycle_seq bcs_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ale     (ale),
  .rd_n    (rd_n),
  .wr_n    (wr_n),
  .inta_n  (inta_n),
  .ready   (ready),
  .hold    (hold),
  .hlda    (hlda),
  .ad_oe   (ad_oe),
  .addr_oe (addr_oe),
  .ctl_oe  (ctl_oe),
  .done    (done)
);

// File: tb/bus_cycle_seq_bench.sv
module bus_cycle_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  // vector: kind[44:42] addr[41:22] wdata[21:14] waits[13:10] rdin[9:2] mode_min[1] hold_mid[0]
  localparam logic [44:0] VEC [NV] = '{
    {3'd4, 20'h12345, 8'h00, 4'd0, 8'hA5, 1'b1, 1'b0},
    {3'd5, 20'hFEDCB, 8'h00, 4'd2, 8'h3C, 1'b1, 1'b0},
    {3'd6, 20'h0F0F0, 8'h96, 4'd1, 8'h00, 1'b1, 1'b0},
    {3'd1, 20'h003F8, 8'h00, 4'd0, 8'h81, 1'b1, 1'b0},
    {3'd2, 20'h00378, 8'h42, 4'd3, 8'h00, 1'b1, 1'b0},
    {3'd0, 20'h00000, 8'h00, 4'd0, 8'h08, 1'b1, 1'b0},
    {3'd0, 20'h00000, 8'h00, 4'd1, 8'h0F, 1'b0, 1'b0},
    {3'd0, 20'h00000, 8'h00, 4'd0, 8'h21, 1'b0, 1'b1},
    {3'd7, 20'h80001, 8'h00, 4'd0, 8'hC3, 1'b1, 1'b0},
    {3'd6, 20'h7FFFF, 8'hFF, 4'd2, 8'h00, 1'b1, 1'b1}
  };

  logic clk, rst_n, mode_min, req_valid, req_ready, done, ready, hold, hlda;
  logic [2:0]  req_kind;
  logic [19:0] req_addr;
  logic [7:0]  req_wdata, rdata, ad_in, ad_out, a_mid;
  logic [3:0]  a_top;
  logic ad_oe, addr_oe, ale, rd_n, wr_n, inta_n, iom, dtr, den_n, lock_n, ctl_oe;

  int checks = 0;
  int errors = 0;

  bus_cycle_seq u_bus_cycle_seq (
    .clk(clk), .rst_n(rst_n), .mode_min(mode_min), .req_valid(req_valid),
    .req_ready(req_ready), .req_kind(req_kind), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .rdata(rdata), .ready(ready),
    .hold(hold), .hlda(hlda), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .a_mid(a_mid), .a_top(a_top), .addr_oe(addr_oe), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .inta_n(inta_n), .iom(iom), .dtr(dtr), .den_n(den_n),
    .lock_n(lock_n), .ctl_oe(ctl_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic run_vec(input logic [2:0] k, input logic [19:0] a, input logic [7:0] wd,
                         input int waits, input logic [7:0] rin, input logic mm, input logic hmid);
    logic is_ack, is_wr, is_io, lowv;
    logic [3:0] stat;
    int ncyc, cnt;
    is_ack = (k == 3'd0);
    is_wr  = (k == 3'd2) || (k == 3'd6);
    is_io  = !k[2];
    stat   = {2'b00, is_wr, is_io};
    ncyc   = (is_ack && !mm) ? 2 : 1;
    @(negedge clk);
    mode_min = mm; req_kind = k; req_addr = a; req_wdata = wd; req_valid = 1'b1; ad_in = 8'hEE;
    #1;
    chk(req_ready == 1'b1, "R1", req_ready, 1);
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      if (c == 0) req_valid = 1'b0;
      chk(ale == 1'b1, "R1", ale, 1);
      if (!is_ack) chk(ad_oe && ad_out == a[7:0], "R3", {ad_oe, ad_out}, {1'b1, a[7:0]});
      chk(a_mid == a[15:8], "R3", a_mid, a[15:8]);
      chk(a_top == a[19:16], "R4", a_top, a[19:16]);
      chk(iom == is_io, "R2", iom, is_io);
      chk(lock_n == !(is_ack && !mm), "R9", lock_n, !(is_ack && !mm));
      if (c == ncyc - 1) ad_in = rin;
      cnt = 0;
      lowv = 1'b1;
      while (lowv && cnt < 40) begin
        @(negedge clk);
        lowv = is_ack ? !inta_n : (is_wr ? !wr_n : !rd_n);
        if (lowv) begin
          cnt++;
          if (cnt == 1) begin
            chk(a_top == stat, "R4", a_top, stat);
            chk(den_n == 1'b0, "R5", den_n, 0);
            chk(({rd_n, wr_n, inta_n} == 3'b011) || ({rd_n, wr_n, inta_n} == 3'b101)
                || ({rd_n, wr_n, inta_n} == 3'b110), "R5", {rd_n, wr_n, inta_n}, 0);
            chk(dtr == is_wr, "R6", dtr, is_wr);
            chk(ad_oe == is_wr, "R6", ad_oe, is_wr);
            if (is_wr) chk(ad_out == wd, "R6", ad_out, wd);
            chk(ale == 1'b0, "R3", ale, 0);
            chk(a_mid == a[15:8], "R3", a_mid, a[15:8]);
            chk(done == 1'b0, "R8", done, 0);
            if (hmid) hold = 1'b1;
          end
          ready = (cnt >= waits + 2);
        end
      end
      ready = 1'b1;
      chk(cnt == waits + 2, "R7", cnt, waits + 2);
      chk(done == (c == ncyc - 1), "R9", done, (c == ncyc - 1));
      chk(a_top == stat, "R4", a_top, stat);
      chk(iom == is_io, "R2", iom, is_io);
      chk(hlda == 1'b0, "R10", hlda, 0);
      if (c == ncyc - 1 && !is_wr) chk(rdata == rin, "R8", rdata, rin);
    end
    @(negedge clk);
    chk(done == 1'b0 && ale == 1'b0, "R8", {done, ale}, 0);
    chk(hlda == 1'b0, "R10", hlda, 0);
    if (hmid) begin
      @(negedge clk);
      chk(hlda == 1'b1, "R10", hlda, 1);
      chk(!ad_oe && !addr_oe && !ctl_oe, "R10", {ad_oe, addr_oe, ctl_oe}, 0);
      hold = 1'b0;
      @(negedge clk);
      chk(hlda == 1'b0, "R11", hlda, 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_min = 1'b1; req_valid = 1'b0; req_kind = 3'd0;
    req_addr = '0; req_wdata = '0; ready = 1'b1; hold = 1'b0; ad_in = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!ale && !done && !hlda && !ad_oe, "R12", {ale, done, hlda, ad_oe}, 0);
    chk(rd_n && wr_n && inta_n && lock_n, "R12", {rd_n, wr_n, inta_n, lock_n}, 4'hF);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [44:0] v;
      v = VEC[i];
      run_vec(v[44:42], v[41:22], v[21:14], int'(v[13:10]), v[9:2], v[1], v[0]);
    end

    // R10 / R11: hold wins over a pending request, then release timing
    @(negedge clk);
    hold = 1'b1; req_valid = 1'b1; req_kind = 3'd5; req_addr = 20'h2468A; mode_min = 1'b1;
    ad_in = 8'h5E;
    #1;
    chk(req_ready == 1'b0, "R1", req_ready, 0);
    @(negedge clk);
    chk(hlda == 1'b1 && ale == 1'b0, "R10", {hlda, ale}, 2'b10);
    chk(!ad_oe && !addr_oe && !ctl_oe, "R10", {ad_oe, addr_oe, ctl_oe}, 0);
    @(negedge clk);
    chk(hlda == 1'b1, "R10", hlda, 1);
    hold = 1'b0;
    @(negedge clk);
    chk(hlda == 1'b0 && ale == 1'b0, "R11", {hlda, ale}, 0);
    chk(req_ready == 1'b1, "R11", req_ready, 1);
    @(negedge clk);
    chk(ale == 1'b1 && ad_out == 8'h8A, "R11", {ale, ad_out}, {1'b1, 8'h8A});
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(done == 1'b1 && rdata == 8'h5E, "R8", {done, rdata}, {1'b1, 8'h5E});
    @(negedge clk);
    chk(done == 1'b0, "R8", done, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule